// File: doc/BRIEF.md
# Power-Down Mode Transition Controller

This block keeps track of which operating mode a processor is in and moves it between those modes. There are three running modes: high-speed, medium-speed and subactive. There are four low-power modes: sleep, subsleep, standby and watch. Software programs an 8-bit control register. The two flags that matter for transitions are a direct-switch flag and a low-clock flag. When the CPU runs its sleep instruction, the block receives a one-cycle sleep strobe. It then picks the target mode from those two flags, the standby-select input and the current mode.

A one-cycle wake strobe brings a low-power mode back to a running mode. Sleep returns to whichever of high-speed or medium-speed it was entered from. Subsleep returns to subactive, and standby returns to high-speed. Leaving watch resumes at high-speed or in subactive, as the low-clock flag selects. The `speed_sel` level input chooses between high-speed and medium-speed while the processor runs on the main clock. The mode is presented as a one-hot vector.

Top module: `pdm_power_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, the mode output is high-speed (bit 0) and the register reads 0x00.
- R2: Register bits 7 (direct-switch flag), 6 (low-clock flag), 5 (noise-filter select) and 1:0 (two-bit field) read back the value last written. Bits 4:2 always read 0 and ignore writes.
- R3: A register write never changes the mode output by itself.
- R4: In high-speed, `speed_sel`=1 gives medium-speed on the next edge. In medium-speed, `speed_sel`=0 gives high-speed on the next edge. In every other mode `speed_sel` has no effect.
- R5: A sleep strobe with `stby_sel`=0 enters sleep (bit 3) from high-speed or medium-speed, and subsleep (bit 4) from subactive.
- R6: A sleep strobe with `stby_sel`=1 and the direct-switch flag at 1 switches directly between clock domains: high/medium-speed goes to subactive (bit 2) when the low-clock flag is 1, and subactive goes to high-speed when the low-clock flag is 0.
- R7: A sleep strobe with `stby_sel`=1 that is not a direct switch enters watch (bit 6) when the low-clock flag is 1.
- R8: A sleep strobe with `stby_sel`=1 and the low-clock flag at 0 that is not a direct switch enters standby (bit 5) from high/medium-speed, and enters watch from subactive.
- R9: A wake strobe returns sleep to the running mode it was entered from, subsleep to subactive, and standby to high-speed.
- R10: A wake strobe in watch resumes at high-speed when the low-clock flag is 0 and in subactive when it is 1.
- R11: A sleep strobe in a low-power mode and a wake strobe in a running mode are ignored.
- R12: Exactly one mode bit is set in every cycle. The mode changes only on the edge that samples a strobe or a `speed_sel` mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write enable, one cycle |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data |
| sleep_req | input | 1 | Sleep-instruction strobe |
| wake_req | input | 1 | Wake-event strobe |
| stby_sel | input | 1 | Standby select (0 = light sleep states) |
| speed_sel | input | 1 | Main-clock speed select (1 = medium) |
| mode_oh | output | 7 | One-hot mode: 0 high, 1 medium, 2 subactive, 3 sleep, 4 subsleep, 5 standby, 6 watch |

## Verification
The assertions assume that the sleep and wake strobes each last one cycle. They also assume the two strobes are never raised together, because an instruction and a wake event never coincide. The quiet-cycle property further takes `speed_sel` to be a level that software moves only while the processor runs. Every directed task drives strobes as single-cycle pulses between falling edges and keeps the two strobes apart. Each task changes `speed_sel` only in the cases where R4 and R11 are being probed.

// File: rtl/pdm_pkg.sv
// Package: shared mode encoding and register field layout for the
// power-down mode controller. Assumes seven modes, index = one-hot bit.
package pdm_pkg;
    localparam int NUM_MODES = 7;
    localparam int MODE_W    = $clog2(NUM_MODES);
    localparam int REG_W     = 8;
    localparam int BIT_DT    = 7;
    localparam int BIT_LS    = 6;
    localparam int BIT_NSEL  = 5;
    localparam logic [REG_W-1:0] WR_MASK = 8'hE3;

    typedef enum logic [MODE_W-1:0] {
        M_HIGH   = 3'd0,
        M_MED    = 3'd1,
        M_SUBACT = 3'd2,
        M_SLEEP  = 3'd3,
        M_SUBSLP = 3'd4,
        M_STBY   = 3'd5,
        M_WATCH  = 3'd6
    } mode_e;
endpackage

// File: rtl/pdm_ctrl_reg.sv
// Control register: holds the writable bits of the 8-bit low-power
// register. Assumes one write per cycle; unimplemented bits read zero.
module pdm_ctrl_reg
    import pdm_pkg::*;
#(
    parameter int W = REG_W,
    parameter logic [W-1:0] MASK = WR_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         dt_flag,
    output logic         ls_flag
);
    logic [W-1:0] reg_q;

    // Capture masked write data; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_q <= '0;
        else if (wr_en) reg_q <= wr_data & MASK;
    end

    // Present the stored value and the two flags used by the mode logic.
    always_comb begin
        rd_data = reg_q;
        dt_flag = reg_q[BIT_DT];
        ls_flag = reg_q[BIT_LS];
    end

    // R2: a write reads back through the mask on the next cycle.
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & MASK));
endmodule

// File: rtl/pdm_next_mode.sv
// Next-mode resolver: purely combinational choice of the following mode
// and of the running mode to return to from sleep. Assumes the sleep and
// wake strobes are never active together.
module pdm_next_mode
    import pdm_pkg::*;
(
    input  mode_e cur,
    input  mode_e ret_cur,
    input  logic  dt_flag,
    input  logic  ls_flag,
    input  logic  stby_sel,
    input  logic  speed_sel,
    input  logic  sleep_req,
    input  logic  wake_req,
    output mode_e nxt,
    output mode_e ret_nxt
);
    logic on_main;
    logic running;

    // Classify the current mode.
    always_comb begin
        on_main = (cur == M_HIGH) || (cur == M_MED);
        running = on_main || (cur == M_SUBACT);
    end

    // Resolve the next mode by strobe, then by speed select.
    always_comb begin
        nxt     = cur;
        ret_nxt = ret_cur;
        if (sleep_req && running) begin
            if (!stby_sel) begin
                nxt = on_main ? M_SLEEP : M_SUBSLP;
                if (on_main) ret_nxt = cur;
            end else if (dt_flag && (ls_flag == on_main)) begin
                nxt = on_main ? M_SUBACT : M_HIGH;
            end else if (ls_flag || !on_main) begin
                nxt = M_WATCH;
            end else begin
                nxt = M_STBY;
            end
        end else if (wake_req && !running) begin
            case (cur)
                M_SLEEP:  nxt = ret_cur;
                M_SUBSLP: nxt = M_SUBACT;
                M_STBY:   nxt = M_HIGH;
                default:  nxt = ls_flag ? M_SUBACT : M_HIGH;
            endcase
        end else if (cur == M_HIGH && speed_sel) begin
            nxt = M_MED;
        end else if (cur == M_MED && !speed_sel) begin
            nxt = M_HIGH;
        end
    end
endmodule

// File: rtl/pdm_mode_fsm.sv
// Mode state register: holds the current mode and the running mode to
// return to from sleep. Assumes one-cycle strobes from the caller.
module pdm_mode_fsm
    import pdm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e nxt,
    input  mode_e ret_nxt,
    input  logic  sleep_req,
    input  logic  wake_req,
    input  logic  ls_flag,
    output mode_e mode_q,
    output mode_e ret_q
);
    // Advance the mode; reset to high-speed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_HIGH;
            ret_q  <= M_HIGH;
        end else begin
            mode_q <= nxt;
            ret_q  <= ret_nxt;
        end
    end

    // R1: reset lands in high-speed.
    a_r1_reset_high: assert property (@(posedge clk)
        !rst_n |=> mode_q == M_HIGH);
    // R9: wake from standby goes to high-speed.
    a_r9_stby_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_STBY && wake_req && !sleep_req) |=> mode_q == M_HIGH);
    // R10: wake from watch follows the low-clock flag.
    a_r10_watch_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_WATCH && wake_req && !sleep_req)
            |=> mode_q == ($past(ls_flag) ? M_SUBACT : M_HIGH));
    // R11: sleep strobe in a low-power mode is ignored.
    a_r11_sleep_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !wake_req &&
         (mode_q == M_SLEEP || mode_q == M_SUBSLP ||
          mode_q == M_STBY  || mode_q == M_WATCH)) |=> $stable(mode_q));
endmodule

// File: rtl/pdm_power_ctrl.sv
// Top: power-down mode controller. Joins the control register, the
// next-mode resolver and the mode register; decodes the mode to one-hot.
// Assumes strobes last one cycle and never coincide.
module pdm_power_ctrl
    import pdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [REG_W-1:0]     reg_wr_data,
    output logic [REG_W-1:0]     reg_rd_data,
    input  logic                 sleep_req,
    input  logic                 wake_req,
    input  logic                 stby_sel,
    input  logic                 speed_sel,
    output logic [NUM_MODES-1:0] mode_oh
);
    logic  dt_flag;
    logic  ls_flag;
    mode_e mode_q;
    mode_e ret_q;
    mode_e nxt;
    mode_e ret_nxt;

    pdm_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .dt_flag (dt_flag),
        .ls_flag (ls_flag)
    );

    pdm_next_mode u_next (
        .cur       (mode_q),
        .ret_cur   (ret_q),
        .dt_flag   (dt_flag),
        .ls_flag   (ls_flag),
        .stby_sel  (stby_sel),
        .speed_sel (speed_sel),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .nxt       (nxt),
        .ret_nxt   (ret_nxt)
    );

    pdm_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt       (nxt),
        .ret_nxt   (ret_nxt),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .ls_flag   (ls_flag),
        .mode_q    (mode_q),
        .ret_q     (ret_q)
    );

    // Decode the mode index to one output bit per mode.
    for (genvar i = 0; i < NUM_MODES; i++) begin : g_dec
        assign mode_oh[i] = (mode_q == mode_e'(i));
    end

    // R12: exactly one mode bit at all times after reset.
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_oh) == 1);
    // R12: no strobe and no speed mismatch keeps the mode.
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_req && !wake_req && !(mode_oh[0] && speed_sel) &&
         !(mode_oh[1] && !speed_sel)) |=> $stable(mode_oh));
endmodule

// File: tb/sim_pdm_power_ctrl.sv
// Directed bench for the power-down mode controller.
module sim_pdm_power_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] HI = 7'b0000001, MD = 7'b0000010, SA = 7'b0000100,
                           SL = 7'b0001000, SS = 7'b0010000, SB = 7'b0100000,
                           WA = 7'b1000000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       stby_sel = 1'b0;
    logic       speed_sel = 1'b0;
    logic [6:0] mode_oh;
    int         checks = 0;
    int         fails = 0;
    int         cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdm_power_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .sleep_req(sleep_req), .wake_req(wake_req), .stby_sel(stby_sel),
        .speed_sel(speed_sel), .mode_oh(mode_oh)
    );

    task automatic chk_mode(input logic [6:0] exp, input string tag);
        checks++;
        if (mode_oh !== exp || $countones(mode_oh) != 1) begin
            fails++;
            $display("FAIL %s mode actual=%b expected=%b", tag, mode_oh, exp);
        end
    endtask

    task automatic chk_rd(input logic [7:0] exp, input string tag);
        checks++;
        if (reg_rd_data !== exp) begin
            fails++;
            $display("FAIL %s reg actual=%h expected=%h", tag, reg_rd_data, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sleep_req = 0; wake_req = 0; stby_sel = 0;
        speed_sel = 0; reg_wr_en = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic sleep_pulse();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic wake_pulse();
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_mode(HI, "R1");
        chk_rd(8'h00, "R1");
    endtask

    task automatic t_regs();
        do_reset();
        wr(8'hFF); chk_rd(8'hE3, "R2");
        chk_mode(HI, "R3");
        wr(8'h1C); chk_rd(8'h00, "R2");
        wr(8'hA1); chk_rd(8'hA1, "R2");
        wr(8'h40); chk_mode(HI, "R3");
    endtask

    task automatic t_speed();
        do_reset();
        @(negedge clk); speed_sel = 1'b1;
        @(negedge clk); chk_mode(MD, "R4");
        speed_sel = 1'b0;
        @(negedge clk); chk_mode(HI, "R4");
        repeat (3) @(negedge clk);
        chk_mode(HI, "R12");
    endtask

    task automatic t_sleep();
        do_reset();
        stby_sel = 1'b0;
        sleep_pulse(); chk_mode(SL, "R5");
        sleep_pulse(); chk_mode(SL, "R11");
        wake_pulse();  chk_mode(HI, "R9");
        @(negedge clk); speed_sel = 1'b1;
        @(negedge clk);
        sleep_pulse(); chk_mode(SL, "R5");
        speed_sel = 1'b0;
        @(negedge clk); chk_mode(SL, "R4");
        speed_sel = 1'b1;
        wake_pulse();  chk_mode(MD, "R9");
        speed_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_direct();
        do_reset();
        wr(8'hC0); stby_sel = 1'b1;
        sleep_pulse(); chk_mode(SA, "R6");
        wake_pulse();  chk_mode(SA, "R11");
        stby_sel = 1'b0;
        sleep_pulse(); chk_mode(SS, "R5");
        wake_pulse();  chk_mode(SA, "R9");
        wr(8'h80); stby_sel = 1'b1;
        sleep_pulse(); chk_mode(HI, "R6");
    endtask

    task automatic t_watch();
        do_reset();
        wr(8'h40); stby_sel = 1'b1;
        sleep_pulse(); chk_mode(WA, "R7");
        wake_pulse();  chk_mode(SA, "R10");
        wr(8'h00);
        sleep_pulse(); chk_mode(WA, "R8");
        wake_pulse();  chk_mode(HI, "R10");
    endtask

    task automatic t_standby();
        do_reset();
        wr(8'h00); stby_sel = 1'b1;
        sleep_pulse(); chk_mode(SB, "R8");
        @(negedge clk); speed_sel = 1'b1;
        @(negedge clk); chk_mode(SB, "R4");
        speed_sel = 1'b0;
        wr(8'hC0); chk_mode(SB, "R3");
        wake_pulse();  chk_mode(HI, "R9");
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures",
                         checks, fails);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_speed();
        t_sleep();
        t_direct();
        t_watch();
        t_standby();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end
endmodule